// File: doc/BRIEF.md
# Data-Ready Flag Controller

This block produces the active-low ready indication for a converter whose conversion engine publishes a fresh result at regular intervals. A falling edge on the ready output tells the host that a new result can be fetched over the serial port. The flag has two rule sets, picked by a mode input. In gated operation, the first serial clock of a read takes it back high, and an unread result makes it pulse high for the whole update window. In pulsed operation, it stays low until the engine is told to start the next conversion.

Next to the dedicated output, the block keeps a status-bit copy of the flag that software can read through the register path. It also drives a select line for the serial output multiplexer. When continuous-read mode is on, the port is selected and no word is being shifted, the serial data pin then shows the ready level. A one-cycle invalid-read flag marks any read clock that lands inside the update window. The conversion timing and the serial shifter are outside this block. It receives a window signal, a start pulse and a single-cycle strobe for each rising serial clock edge, all already in the system-clock domain.

Top module: `drdy_ctrl`

## Requirements
- R1: While reset is applied, and for as long as the inputs stay idle after it, `drdy_n` is 1, `drdy_bit` is 1 and `rd_invalid` is 0.
- R2: In both modes, the cycle after the first cycle in which `upd_win` is 0 following a cycle in which it was 1 (the window end), `drdy_n` is 0.
- R3: With `mode_pulse`=0, a `sclk_rise` strobe with `cs_n`=0 and no window end in that cycle makes `drdy_n` 1 in the next cycle.
- R4: With `mode_pulse`=0, every cycle in which `upd_win` is 1 makes `drdy_n` 1 in the next cycle, so an unread result gives a high pulse as long as the window.
- R5: With `mode_pulse`=1, `sclk_rise` and `upd_win` do not change `drdy_n`. A `conv_start` pulse with no window end in the same cycle makes `drdy_n` 1 in the next cycle.
- R6: With `mode_pulse`=0, `conv_start` has no effect on `drdy_n`.
- R7: `sclk_rise` has no effect on `drdy_n` while `cs_n` is 1, and the window rules of R2 and R4 keep working while `cs_n` is 1.
- R8: `rd_invalid` is 1 for exactly the cycle after a cycle with `sclk_rise`=1, `upd_win`=1 and `cs_n`=0, in either mode, and 0 in every other cycle.
- R9: When `rdatac` is 0 in a cycle, `drdy_bit` equals `drdy_n` in the next cycle. When `rdatac` is 1, `drdy_bit` keeps its value.
- R10: `dout_sel` is 1 in the same cycle exactly when `rdatac`=1, `cs_n`=0 and `shifting`=0.
- R11: A window end wins over a read strobe or a `conv_start` in the same cycle: `drdy_n` goes to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_pulse | input | 1 | 0 selects gated rules, 1 selects pulsed rules |
| rdatac | input | 1 | Continuous-read mode is active |
| cs_n | input | 1 | Serial port select, active low |
| sclk_rise | input | 1 | One-cycle strobe per rising serial clock edge |
| shifting | input | 1 | The serial shifter is moving a data word |
| upd_win | input | 1 | High during the data-update window before new data |
| conv_start | input | 1 | One-cycle pulse that starts a conversion |
| drdy_n | output | 1 | Active-low ready output |
| drdy_bit | output | 1 | Status-register copy of the ready level |
| dout_sel | output | 1 | Selects the ready level onto the serial data pin |
| rd_invalid | output | 1 | One-cycle flag for a read clock inside the update window |

## Verification
The assertions assume that the update window is one unbroken run of high cycles, no longer than the configured window length, and that every strobe input lasts a single cycle. One assertion checks the window length with a counter. The stimulus builds a fixed frame: a start pulse early, then a window of exactly the configured length, then idle time. It adds pseudo-random read strobes, select changes and shifter activity, so the inputs never break these assumptions. Every combination of mode, default select level and continuous-read phase is swept. One extra start pulse is placed on a window end, so the priority rule is exercised in both modes.

// File: rtl/drdy_pkg.sv
package drdy_pkg;
  typedef enum logic {
    MODE_GATED  = 1'b0,
    MODE_PULSED = 1'b1
  } rdy_mode_e;
endpackage

// File: rtl/drdy_win_edge.sv
module drdy_win_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_win,
  output logic upd_end
);
  logic upd_q;
  logic upd_q_d;

  always_comb begin
    upd_q_d = upd_win;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= 1'b0;
    end else begin
      upd_q <= upd_q_d;
    end
  end

  assign upd_end = upd_q & ~upd_win;

  // R2: a window end lasts one cycle
  a_r2_end_single: assert property (@(posedge clk) disable iff (!rst_n)
    upd_end |=> !upd_end);
endmodule

// File: rtl/drdy_core.sv
module drdy_core
  import drdy_pkg::*;
#(
  parameter int WIN_LEN = 20
) (
  input  logic      clk,
  input  logic      rst_n,
  input  rdy_mode_e mode,
  input  logic      upd_win,
  input  logic      upd_end,
  input  logic      conv_start,
  input  logic      sclk_rise,
  input  logic      cs_n,
  output logic      drdy_n,
  output logic      drdy_d,
  output logic      rd_invalid
);
  localparam int CNT_W = $clog2(WIN_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WIN_LEN);

  logic drdy_q, drdy_en;
  logic inv_q, inv_d;
  logic rd_sel;
  logic [CNT_W-1:0] win_cnt, win_cnt_d;

  always_comb begin
    rd_sel = sclk_rise & ~cs_n;
    drdy_d = drdy_q;
    if (mode == MODE_PULSED) begin
      if (upd_end)         drdy_d = 1'b0;
      else if (conv_start) drdy_d = 1'b1;
    end else begin
      if (upd_end)      drdy_d = 1'b0;
      else if (upd_win) drdy_d = 1'b1;
      else if (rd_sel)  drdy_d = 1'b1;
    end
    drdy_en = drdy_d ^ drdy_q;
    inv_d   = rd_sel & upd_win;
    if (!upd_win)              win_cnt_d = '0;
    else if (win_cnt == CNT_MAX) win_cnt_d = win_cnt;
    else                       win_cnt_d = win_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drdy_q  <= 1'b1;
      inv_q   <= 1'b0;
      win_cnt <= '0;
    end else begin
      if (drdy_en) drdy_q <= drdy_d;
      inv_q   <= inv_d;
      win_cnt <= win_cnt_d;
    end
  end

  assign drdy_n     = drdy_q;
  assign rd_invalid = inv_q;

  // R4: input assumption, window not longer than WIN_LEN cycles
  a_r4_win_len: assert property (@(posedge clk) disable iff (!rst_n)
    upd_win |-> (win_cnt < CNT_MAX));
  a_r2_ready_falls: assert property (@(posedge clk) disable iff (!rst_n)
    upd_end |=> !drdy_n);
  a_r4_window_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_GATED && upd_win) |=> drdy_n);
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_GATED && sclk_rise && !cs_n && !upd_end) |=> drdy_n);
  a_r5_pulsed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PULSED && !conv_start && !upd_end) |=> $stable(drdy_n));
  a_r7_deselect_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_GATED && cs_n && !upd_win && !upd_end) |=> $stable(drdy_n));
  a_r8_invalid_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rd_invalid |-> $past(sclk_rise && upd_win && !cs_n));
endmodule

// File: rtl/drdy_status.sv
module drdy_status (
  input  logic clk,
  input  logic rst_n,
  input  logic rdatac,
  input  logic cs_n,
  input  logic shifting,
  input  logic drdy_n,
  input  logic drdy_d,
  output logic drdy_bit,
  output logic dout_sel
);
  logic bit_q, bit_en;

  always_comb begin
    bit_en = ~rdatac;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b1;
    end else if (bit_en) begin
      bit_q <= drdy_d;
    end
  end

  assign drdy_bit = bit_q;
  assign dout_sel = rdatac & ~cs_n & ~shifting;

  a_r9_bit_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !rdatac |=> (drdy_bit == drdy_n));
  a_r9_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rdatac |=> $stable(drdy_bit));
  a_r10_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    shifting |-> !dout_sel);
endmodule

// File: rtl/drdy_ctrl.sv
module drdy_ctrl
  import drdy_pkg::*;
#(
  parameter int WIN_LEN     = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_pulse,
  input  logic rdatac,
  input  logic cs_n,
  input  logic sclk_rise,
  input  logic shifting,
  input  logic upd_win,
  input  logic conv_start,
  output logic drdy_n,
  output logic drdy_bit,
  output logic dout_sel,
  output logic rd_invalid
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic      rst_n_int;
  logic      upd_end;
  logic      drdy_d;
  rdy_mode_e mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_int = rst_pipe[SYNC_STAGES-1];
  assign mode      = rdy_mode_e'(mode_pulse);

  drdy_win_edge i_win_edge (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .upd_win (upd_win),
    .upd_end (upd_end)
  );

  drdy_core #(.WIN_LEN(WIN_LEN)) i_core (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .mode       (mode),
    .upd_win    (upd_win),
    .upd_end    (upd_end),
    .conv_start (conv_start),
    .sclk_rise  (sclk_rise),
    .cs_n       (cs_n),
    .drdy_n     (drdy_n),
    .drdy_d     (drdy_d),
    .rd_invalid (rd_invalid)
  );

  drdy_status i_status (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .rdatac   (rdatac),
    .cs_n     (cs_n),
    .shifting (shifting),
    .drdy_n   (drdy_n),
    .drdy_d   (drdy_d),
    .drdy_bit (drdy_bit),
    .dout_sel (dout_sel)
  );
endmodule

// File: tb/test_drdy_ctrl.sv
module test_drdy_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WIN_LEN    = 20;
  localparam int FRAME      = 60;
  localparam int WIN_START  = 30;
  localparam int RUN_LEN    = 4 * FRAME;

  logic clk = 1'b0;
  logic rst_n, mode_pulse, rdatac, cs_n, sclk_rise, shifting, upd_win, conv_start;
  logic drdy_n, drdy_bit, dout_sel, rd_invalid;
  int   n_cmp = 0;
  int   n_bad = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic  m_updq, m_drdy, m_bit, m_inv;
  string m_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  drdy_ctrl #(.WIN_LEN(WIN_LEN)) i_drdy_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_pulse(mode_pulse), .rdatac(rdatac),
    .cs_n(cs_n), .sclk_rise(sclk_rise), .shifting(shifting),
    .upd_win(upd_win), .conv_start(conv_start), .drdy_n(drdy_n),
    .drdy_bit(drdy_bit), .dout_sel(dout_sel), .rd_invalid(rd_invalid)
  );

  // expected behaviour derived from R2..R11
  always @(posedge clk or negedge rst_n) begin
    logic  nd, ev, rd;
    string t;
    if (!rst_n) begin
      m_updq <= 1'b0; m_drdy <= 1'b1; m_bit <= 1'b1; m_inv <= 1'b0; m_tag <= "R1";
    end else begin
      ev = m_updq && !upd_win;
      rd = sclk_rise && !cs_n;
      nd = m_drdy;
      t  = "R2";
      if (mode_pulse) begin
        if (ev) begin nd = 1'b0; t = conv_start ? "R11" : "R2"; end
        else if (conv_start) begin nd = 1'b1; t = "R5"; end
        else t = "R5";
      end else begin
        if (ev) begin nd = 1'b0; t = (sclk_rise || conv_start) ? "R11" : "R2"; end
        else if (upd_win) begin nd = 1'b1; t = "R4"; end
        else if (rd) begin nd = 1'b1; t = "R3"; end
        else if (sclk_rise) t = "R7";
        else if (conv_start) t = "R6";
      end
      m_updq <= upd_win;
      m_drdy <= nd;
      m_tag  <= t;
      m_inv  <= rd && upd_win;
      if (!rdatac) m_bit <= nd;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; mode_pulse = 1'b0; rdatac = 1'b0; cs_n = 1'b1;
    sclk_rise = 1'b0; shifting = 1'b0; upd_win = 1'b0; conv_start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 drdy_n", drdy_n, 1'b1);
    chk("R1 drdy_bit", drdy_bit, 1'b1);
    chk("R1 rd_invalid", rd_invalid, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 drdy_n idle", drdy_n, 1'b1);
    chk("R1 drdy_bit idle", drdy_bit, 1'b1);
    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int cyc = 0; cyc < RUN_LEN; cyc++) begin
        @(negedge clk);
        chk(m_tag, drdy_n, m_drdy);
        chk("R9", drdy_bit, m_bit);
        chk("R8", rd_invalid, m_inv);
        chk("R10", dout_sel, rdatac & ~cs_n & ~shifting);
        lfsr       = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mode_pulse = cfg[0];
        cs_n       = cfg[1] ? 1'b1 : (lfsr[7] & lfsr[8]);
        rdatac     = cfg[2] ^ ((cyc % (2 * FRAME)) >= FRAME);
        sclk_rise  = lfsr[0] & lfsr[3];
        shifting   = lfsr[5];
        upd_win    = ((cyc % FRAME) >= WIN_START) && ((cyc % FRAME) < WIN_START + WIN_LEN);
        conv_start = ((cyc % FRAME) == 10) || (cyc == 170);
      end
    end
    @(negedge clk);
    chk(m_tag, drdy_n, m_drdy);
    chk("R9", drdy_bit, m_bit);
    finish_run();
  end
endmodule